// File: doc/BRIEF.md
# Palette Lookup with Window Blanking

This block is the last stage of a video pipeline. On every pixel clock it receives a 13-bit colour index from the priority mixer upstream. It presents that index as the read address to three external palette memories: one for red, one for green, one for blue. It then forwards the returned 8-bit components to the DAC. When the beam lies outside a rectangular visible window, it forces the colour to black instead.

Four 16-bit clip values set the window. They are compared directly against the raw horizontal and vertical beam counters, with no offset applied. The left and top edges are inclusive and the right and bottom edges are exclusive. Software may make the window asymmetric and may move it from one frame to the next, for example to close an iris around a character.

The blanking decision is made when the pixel enters the block. That decision is then delayed by the palette read latency, so it leaves together with the colour data that belongs to the same pixel. A shadow copy of the clip values is refreshed only at line start, so a write in the middle of a line cannot tear that line.

Top module: `pal_window_out`

## Requirements
- R1: `pal_addr_o` equals the `color_idx_i` sampled on the previous rising clock edge.
- R2: For a visible pixel sampled at edge k, the output register holds the palette data returned for its index after edge k+RD_LAT+1. Here RD_LAT is the number of clock edges from the address to the data on the palette ports.
- R3: A pixel is visible when left <= x < right and top <= y < bottom. The comparison is unsigned 16-bit on the raw beam counters, with no offset. A pixel on the right or bottom value is blank, and a pixel on the left or top value is shown.
- R4: A valid pixel outside the window leaves the block with red, green and blue all zero.
- R5: When left >= right or top >= bottom, the window is empty and every pixel is black.
- R6: The clip inputs are captured when `line_start_i` is high. The pixel presented in that same cycle already uses the new values. Changes on the clip inputs at any other time have no effect until the next line start.
- R7: `pix_valid_o` follows `pix_valid_i` with the same latency as the colour data. Whenever `pix_valid_o` is low, the colour outputs are zero.
- R8: Reset clears `pix_valid_o` and the colour outputs and sets all four captured clip values to zero. As a result, every pixel stays black until the first line start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_valid_i | input | 1 | Pixel present this cycle |
| color_idx_i | input | 13 | Colour index from the mixer |
| beam_x_i | input | 16 | Raw horizontal beam counter |
| beam_y_i | input | 16 | Raw vertical beam counter |
| line_start_i | input | 1 | First pixel cycle of a line; captures clip values |
| clip_left_i | input | 16 | First visible column |
| clip_right_i | input | 16 | Column one past the last visible one |
| clip_top_i | input | 16 | First visible line |
| clip_bottom_i | input | 16 | Line one past the last visible one |
| pal_addr_o | output | 13 | Read address to the three palette memories |
| pal_r_i | input | 8 | Red data from palette memory |
| pal_g_i | input | 8 | Green data from palette memory |
| pal_b_i | input | 8 | Blue data from palette memory |
| pix_valid_o | output | 1 | Output pixel present |
| red_o | output | 8 | Red to DAC |
| green_o | output | 8 | Green to DAC |
| blue_o | output | 8 | Blue to DAC |

## Verification
The bench builds the block with RD_LAT set to 3 rather than the default 2. This gives three delay stages for the blanking flag, so an off-by-one between the flag delay and the memory latency shows up as black and coloured pixels shifted against the reference. The bench memory model returns a non-zero colour for every index, so a wrongly blanked pixel can never match by accident. Short lines of 32 pixels let the sweep cross both horizontal edges, both vertical edges and the line-start capture many times within a few thousand cycles.

// File: rtl/pal_window_pkg.sv
package pal_window_pkg;

  localparam int unsigned IDX_W = 13;
  localparam int unsigned CH_W  = 8;
  localparam int unsigned POS_W = 16;

  typedef logic [POS_W-1:0] pos_t;

  typedef struct packed {
    pos_t left;
    pos_t right;
    pos_t top;
    pos_t bottom;
  } clip_t;

  typedef struct packed {
    logic [CH_W-1:0] r;
    logic [CH_W-1:0] g;
    logic [CH_W-1:0] b;
  } rgb_t;

endpackage

// File: rtl/pal_clip_shadow.sv
module pal_clip_shadow
  import pal_window_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  line_start_i,
  input  clip_t live_i,
  output clip_t eff_o
);

  clip_t shadow_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= '0;
    end else if (line_start_i) begin
      shadow_q <= live_i;
    end
  end

  // the pixel that arrives with the line-start pulse already sees the new edges
  assign eff_o = line_start_i ? live_i : shadow_q;

  // R6
  shadow_load_chk: assert property (@(posedge clk) disable iff (rst)
    line_start_i |=> (shadow_q == $past(live_i)));

  // R6
  shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !line_start_i |=> $stable(shadow_q));

endmodule

// File: rtl/pal_window_cmp.sv
module pal_window_cmp
  import pal_window_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  valid_i,
  input  pos_t  x_i,
  input  pos_t  y_i,
  input  clip_t clip_i,
  output logic  valid_o,
  output logic  vis_o
);

  logic in_x, in_y;
  logic empty_win;

  assign in_x = (x_i >= clip_i.left) && (x_i < clip_i.right);
  assign in_y = (y_i >= clip_i.top)  && (y_i < clip_i.bottom);

  // only used by the checker below
  assign empty_win = (clip_i.left >= clip_i.right) || (clip_i.top >= clip_i.bottom);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      vis_o   <= 1'b0;
    end else begin
      valid_o <= valid_i;
      vis_o   <= valid_i && in_x && in_y;
    end
  end

  // R5
  empty_window_chk: assert property (@(posedge clk) disable iff (rst)
    empty_win |=> !vis_o);

  // R7
  vis_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    vis_o |-> valid_o);

endmodule

// File: rtl/pal_delay_line.sv
module pal_delay_line #(
  parameter int unsigned WIDTH = 2,
  parameter int unsigned DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  generate
    if (DEPTH == 0) begin : g_pass
      assign q_o = d_i;
    end else begin : g_pipe
      logic [WIDTH-1:0] st_q [DEPTH];

      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < DEPTH; i++) st_q[i] <= '0;
        end else begin
          st_q[0] <= d_i;
          for (int i = 1; i < DEPTH; i++) st_q[i] <= st_q[i-1];
        end
      end

      assign q_o = st_q[DEPTH-1];
    end
  endgenerate

endmodule

// File: rtl/pal_window_out.sv
module pal_window_out
  import pal_window_pkg::*;
#(
  parameter int unsigned RD_LAT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pix_valid_i,
  input  logic [IDX_W-1:0] color_idx_i,
  input  logic [POS_W-1:0] beam_x_i,
  input  logic [POS_W-1:0] beam_y_i,
  input  logic             line_start_i,
  input  logic [POS_W-1:0] clip_left_i,
  input  logic [POS_W-1:0] clip_right_i,
  input  logic [POS_W-1:0] clip_top_i,
  input  logic [POS_W-1:0] clip_bottom_i,
  output logic [IDX_W-1:0] pal_addr_o,
  input  logic [CH_W-1:0]  pal_r_i,
  input  logic [CH_W-1:0]  pal_g_i,
  input  logic [CH_W-1:0]  pal_b_i,
  output logic             pix_valid_o,
  output logic [CH_W-1:0]  red_o,
  output logic [CH_W-1:0]  green_o,
  output logic [CH_W-1:0]  blue_o
);

  localparam int unsigned FLAG_W = 2;

  clip_t live_clip, eff_clip;
  logic  cmp_valid, cmp_vis;
  logic [FLAG_W-1:0] flag_dly;
  logic [IDX_W-1:0]  addr_q;
  rgb_t  out_q;
  logic  valid_q;

  assign live_clip = '{left: clip_left_i, right: clip_right_i,
                       top: clip_top_i, bottom: clip_bottom_i};

  pal_clip_shadow u_shadow (
    .clk          (clk),
    .rst          (rst),
    .line_start_i (line_start_i),
    .live_i       (live_clip),
    .eff_o        (eff_clip)
  );

  pal_window_cmp u_cmp (
    .clk     (clk),
    .rst     (rst),
    .valid_i (pix_valid_i),
    .x_i     (beam_x_i),
    .y_i     (beam_y_i),
    .clip_i  (eff_clip),
    .valid_o (cmp_valid),
    .vis_o   (cmp_vis)
  );

  // address register launches the palette read in step with the window decision
  always_ff @(posedge clk) begin
    addr_q <= color_idx_i;
  end
  assign pal_addr_o = addr_q;

  pal_delay_line #(
    .WIDTH (FLAG_W),
    .DEPTH (RD_LAT)
  ) u_align (
    .clk (clk),
    .rst (rst),
    .d_i ({cmp_valid, cmp_vis}),
    .q_o (flag_dly)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      out_q   <= '0;
    end else begin
      valid_q <= flag_dly[1];
      out_q   <= flag_dly[0] ? rgb_t'{r: pal_r_i, g: pal_g_i, b: pal_b_i} : rgb_t'('0);
    end
  end

  assign pix_valid_o = valid_q;
  assign red_o       = out_q.r;
  assign green_o     = out_q.g;
  assign blue_o      = out_q.b;

  // R1
  addr_follow_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (pal_addr_o == $past(color_idx_i)));

  // R7
  idle_black_chk: assert property (@(posedge clk) disable iff (rst)
    !pix_valid_o |-> (red_o == '0 && green_o == '0 && blue_o == '0));

  // R8
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!pix_valid_o && red_o == '0 && green_o == '0 && blue_o == '0));

endmodule

// File: tb/pal_window_out_tb.sv
module pal_window_out_tb_top;

  localparam int RD_LAT = 3;
  localparam int LAT    = RD_LAT + 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pix_valid_i = 1'b0;
  logic [12:0] color_idx_i = '0;
  logic [15:0] beam_x_i = '0, beam_y_i = '0;
  logic        line_start_i = 1'b0;
  logic [15:0] clip_left_i = '0, clip_right_i = '0, clip_top_i = '0, clip_bottom_i = '0;
  logic [12:0] pal_addr_o;
  logic [7:0]  pal_r_i, pal_g_i, pal_b_i;
  logic        pix_valid_o;
  logic [7:0]  red_o, green_o, blue_o;

  always #5 clk = ~clk;

  pal_window_out #(.RD_LAT(RD_LAT)) dut_i (
    .clk(clk), .rst(rst), .pix_valid_i(pix_valid_i), .color_idx_i(color_idx_i),
    .beam_x_i(beam_x_i), .beam_y_i(beam_y_i), .line_start_i(line_start_i),
    .clip_left_i(clip_left_i), .clip_right_i(clip_right_i),
    .clip_top_i(clip_top_i), .clip_bottom_i(clip_bottom_i),
    .pal_addr_o(pal_addr_o), .pal_r_i(pal_r_i), .pal_g_i(pal_g_i), .pal_b_i(pal_b_i),
    .pix_valid_o(pix_valid_o), .red_o(red_o), .green_o(green_o), .blue_o(blue_o)
  );

  function automatic logic [23:0] pal_f(logic [12:0] a);
    logic [7:0] r, g, b;
    r = a[7:0] ^ 8'hA5;
    g = a[12:5] + 8'd3;
    b = {a[3:0], a[12:9]} | 8'h01;
    return {r, g, b};
  endfunction

  // palette memory model: RD_LAT edges from address to data
  logic [23:0] ram_pipe [RD_LAT];
  always_ff @(posedge clk) begin
    ram_pipe[0] <= pal_f(pal_addr_o);
    for (int i = 1; i < RD_LAT; i++) ram_pipe[i] <= ram_pipe[i-1];
  end
  assign {pal_r_i, pal_g_i, pal_b_i} = ram_pipe[RD_LAT-1];

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  bit have_prev = 0;
  logic [12:0] prev_color;
  int mode = 0;

  bit          q_v [$];
  logic [23:0] q_rgb [$];
  string       q_tag [$];
  int unsigned sh_l = 0, sh_r = 0, sh_t = 0, sh_b = 0;

  task automatic check_outputs();
    bit ev; logic [23:0] er; string tg;
    if (have_prev) begin
      total++;
      if (pal_addr_o !== prev_color) begin
        bad++;
        $display("FAIL R1 addr actual=%h expected=%h", pal_addr_o, prev_color);
      end
    end
    if (q_v.size() >= LAT) begin
      ev = q_v.pop_front(); er = q_rgb.pop_front(); tg = q_tag.pop_front();
      total++;
      if (pix_valid_o !== ev || {red_o, green_o, blue_o} !== er) begin
        bad++;
        $display("FAIL %s out actual=%b/%h expected=%b/%h", tg, pix_valid_o,
                 {red_o, green_o, blue_o}, ev, er);
      end
    end
  endtask

  task automatic drive(bit v, int x, int y, bit ls, logic [12:0] c);
    bit vis, empty; string tg;
    @(negedge clk);
    check_outputs();
    pix_valid_i = v; beam_x_i = 16'(x); beam_y_i = 16'(y);
    line_start_i = ls; color_idx_i = c;
    prev_color = c; have_prev = 1;
    if (rst) begin
      q_v.push_back(0); q_rgb.push_back('0); q_tag.push_back("R8");
      return;
    end
    if (ls) begin
      sh_l = clip_left_i; sh_r = clip_right_i; sh_t = clip_top_i; sh_b = clip_bottom_i;
    end
    vis   = v && x >= sh_l && x < sh_r && y >= sh_t && y < sh_b;
    empty = (sh_l >= sh_r) || (sh_t >= sh_b);
    if (!v) tg = "R7";
    else if (mode == 1) tg = "R8";
    else if (mode == 3) tg = "R6";
    else if (empty) tg = "R5";
    else if (x == sh_l || x == sh_r || y == sh_t || y == sh_b ||
             x == sh_r - 1 || x == sh_l - 1) tg = "R3";
    else if (vis) tg = "R2";
    else tg = "R4";
    q_v.push_back(v);
    q_rgb.push_back(vis ? pal_f(c) : 24'h0);
    q_tag.push_back(tg);
  endtask

  task automatic run_frame(int lines, int l, int r, int t, int b, bit gaps, bit midchg);
    for (int y = 0; y < lines; y++) begin
      for (int x = 0; x < 32; x++) begin
        clip_left_i = 16'(l); clip_right_i = 16'(r);
        clip_top_i = 16'(t); clip_bottom_i = 16'(b);
        if (midchg && x >= 16) begin
          clip_left_i = 16'h0; clip_right_i = 16'hFFFF;
          clip_top_i = 16'h0; clip_bottom_i = 16'hFFFF;
        end
        drive(gaps ? (x % 3 != 0) : 1'b1, x, y, x == 0,
              13'((y * 37 + x * 5 + 1) % 8192));
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R8: reset state
    for (int i = 0; i < 4; i++) drive(0, 0, 0, 0, 13'd0);
    @(negedge clk);
    total++;
    if (pix_valid_o !== 1'b0 || {red_o, green_o, blue_o} !== 24'h0) begin
      bad++;
      $display("FAIL R8 reset actual=%b/%h expected=0/000000", pix_valid_o,
               {red_o, green_o, blue_o});
    end
    rst = 0;
    // R8: captured clip values are zero until first line start
    mode = 1;
    clip_left_i = 0; clip_right_i = 100; clip_top_i = 0; clip_bottom_i = 100;
    for (int i = 0; i < 12; i++) drive(1, i, 1, 0, 13'(i + 50));
    // R2 R3 R4: asymmetric window sweep including all edges
    mode = 2;
    run_frame(7, 10, 20, 2, 5, 0, 0);
    run_frame(6, 3, 29, 1, 4, 0, 0);
    // R7: gaps in the pixel stream
    run_frame(4, 5, 25, 0, 3, 1, 0);
    // R6: mid-line changes of the clip inputs are not taken until line start
    mode = 3;
    run_frame(3, 12, 14, 0, 2, 0, 1);
    // R5: empty windows
    mode = 2;
    run_frame(3, 20, 20, 0, 8, 0, 0);
    run_frame(3, 2, 30, 6, 1, 0, 0);
    // flush
    for (int i = 0; i < LAT + 2; i++) drive(0, 0, 0, 0, 13'd0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule